// File: doc/BRIEF.md
# Grouped-Register Three-Operand ALU

This unit executes one register-to-register arithmetic instruction per clock. A 16-bit instruction word carries a 4-bit group code and three 4-bit offsets: two source operands and one destination. Instead of treating the offsets as flat register numbers, the group code picks one of sixteen legal combinations of register groups for the three slots. Each offset then selects an entry inside its group.

There are four groups. The auxiliary group and the extra group each hold twelve registers and four stack options. The local group holds sixteen registers. The constant group is a read-only bank of sixteen values. The two sources are read combinationally and passed through a 32-bit ALU. The result is written back on the clock edge that accepts the instruction. It also appears on the result port one cycle later, together with the destination group and offset. An instruction can pop and push the shared operand stack within that single cycle.

Top module: `grp_alu_unit`

## Requirements
- R1: After synchronous reset, `res_valid` is 0, every auxiliary, local and extra register is 0, every stack slot is 0 and the stack pointer is 0.
- R2: Fields: `instr[15:12]` is the group code, `[11:8]` is the first-source offset Ra, `[7:4]` is the second-source offset Rb and `[3:0]` is the destination offset Rc. Groups are encoded aux=0, local=1, extra=2, const=3. Codes 0..15 map, as dest←srcA op srcB, to: A←A·A, A←C·A, L←L·L, L←L·X, L←X·L, L←X·X, L←C·L, L←C·X, X←L·L, X←L·X, X←X·L, X←X·X, X←C·L, X←C·X, L←C·C, X←C·C.
- R3: As a consequence of R2, no code writes a constant, no code mixes auxiliary with local or extra, and a constant appears as srcB only when srcA is also a constant.
- R4: The constant bank at offsets 0..15 holds 0, 1, 2, 3, 4, -2, -1, 0x8000, 0x80000000, 5, 8, 16, -4, -8, 0xFF, 0xFFFF.
- R5: When `lit_mode` is 1 and srcB is a constant, srcB is the Rb field shifted left by 3 and zero-extended (0, 8, …, 120). When `lit_mode` is 0, srcB is the bank entry.
- R6: `alu_op` selects 0 add, 1 subtract (srcA − srcB), 2 AND, 3 OR, 4 XOR. Codes 5..7 pass srcA through.
- R7: In the auxiliary or extra group, source offsets 12, 14 and 15 read the stack top, and offset 13 reads the top and pops it. If srcA pops, a srcB stack read sees the slot below the one srcA read. Pointer arithmetic wraps modulo the stack depth (8 by default).
- R8: In the auxiliary or extra group, destination offset 14 pushes, writing the slot above the top that remains after the source pops. Destination offsets 12, 13 and 15 overwrite that remaining top.
- R9: Each cycle with `issue` high produces exactly one result: in the next cycle `res_valid` is 1, `res_data` is the ALU result, `res_group` is the destination group and `res_index` is Rc. A following instruction reads the updated state.
- R10: While `issue` is low, the instruction and operation inputs have no effect: `res_valid` stays 0 and no register, stack slot or stack pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Execute `instr` on this edge |
| instr | input | 16 | Group code and three offsets |
| alu_op | input | 3 | ALU operation select |
| lit_mode | input | 1 | Constant srcB taken as shifted literal |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | 32 | ALU result that was written back |
| res_group | output | 2 | Destination group of that result |
| res_index | output | 4 | Destination offset of that result |

## Verification
The assertions assume that `issue`, `instr` and `alu_op` are known, settled values at every clock edge after reset. They also assume that the group code is decoded only while `issue` is high, so the legality checks on decoded groups apply only to accepted instructions. The bench changes inputs only on the falling edge and keeps `issue` at a clean 0 or 1. Because every 4-bit code is legal, random instructions cover the full code space without filtering. Invalid garbage is fed only while `issue` is low, to show that it is ignored.

// File: rtl/grp_alu_pkg.sv
package grp_alu_pkg;

    localparam int DATA_W   = 32;
    localparam int OFS_W    = 4;
    localparam int GRP_SIZE = 1 << OFS_W;
    localparam int NUM_FILE = 3;

    typedef enum logic [1:0] {
        GRP_A = 2'd0,
        GRP_L = 2'd1,
        GRP_X = 2'd2,
        GRP_C = 2'd3
    } grp_e;

    typedef struct packed {
        grp_e ga;
        grp_e gb;
        grp_e gc;
    } grp_sel_t;

    localparam logic [OFS_W-1:0] OFS_TOP  = 4'd12;
    localparam logic [OFS_W-1:0] OFS_POP  = 4'd13;
    localparam logic [OFS_W-1:0] OFS_PUSH = 4'd14;

    function automatic grp_sel_t mk_sel(input grp_e a, input grp_e b, input grp_e c);
        grp_sel_t s;
        s.ga = a;
        s.gb = b;
        s.gc = c;
        return s;
    endfunction

    function automatic grp_sel_t decode_groups(input logic [3:0] code);
        grp_sel_t s;
        case (code)
            4'd0:    s = mk_sel(GRP_A, GRP_A, GRP_A);
            4'd1:    s = mk_sel(GRP_C, GRP_A, GRP_A);
            4'd2:    s = mk_sel(GRP_L, GRP_L, GRP_L);
            4'd3:    s = mk_sel(GRP_L, GRP_X, GRP_L);
            4'd4:    s = mk_sel(GRP_X, GRP_L, GRP_L);
            4'd5:    s = mk_sel(GRP_X, GRP_X, GRP_L);
            4'd6:    s = mk_sel(GRP_C, GRP_L, GRP_L);
            4'd7:    s = mk_sel(GRP_C, GRP_X, GRP_L);
            4'd8:    s = mk_sel(GRP_L, GRP_L, GRP_X);
            4'd9:    s = mk_sel(GRP_L, GRP_X, GRP_X);
            4'd10:   s = mk_sel(GRP_X, GRP_L, GRP_X);
            4'd11:   s = mk_sel(GRP_X, GRP_X, GRP_X);
            4'd12:   s = mk_sel(GRP_C, GRP_L, GRP_X);
            4'd13:   s = mk_sel(GRP_C, GRP_X, GRP_X);
            4'd14:   s = mk_sel(GRP_C, GRP_C, GRP_L);
            default: s = mk_sel(GRP_C, GRP_C, GRP_X);
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] const_entry(input logic [OFS_W-1:0] idx);
        logic [DATA_W-1:0] v;
        case (idx)
            4'd0:    v = 32'h0000_0000;
            4'd1:    v = 32'h0000_0001;
            4'd2:    v = 32'h0000_0002;
            4'd3:    v = 32'h0000_0003;
            4'd4:    v = 32'h0000_0004;
            4'd5:    v = 32'hFFFF_FFFE;
            4'd6:    v = 32'hFFFF_FFFF;
            4'd7:    v = 32'h0000_8000;
            4'd8:    v = 32'h8000_0000;
            4'd9:    v = 32'h0000_0005;
            4'd10:   v = 32'h0000_0008;
            4'd11:   v = 32'h0000_0010;
            4'd12:   v = 32'hFFFF_FFFC;
            4'd13:   v = 32'hFFFF_FFF8;
            4'd14:   v = 32'h0000_00FF;
            default: v = 32'h0000_FFFF;
        endcase
        return v;
    endfunction

    function automatic logic is_stack_slot(input grp_e g, input logic [OFS_W-1:0] idx);
        return (g == GRP_A || g == GRP_X) && (idx >= OFS_TOP);
    endfunction

endpackage

// File: rtl/grp_alu_decode.sv
module grp_alu_decode
    import grp_alu_pkg::*;
(
    input  logic [3:0] code,
    output grp_sel_t   sel
);
    assign sel = decode_groups(code);
endmodule

// File: rtl/grp_alu_alu.sv
module grp_alu_alu
    import grp_alu_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        case (op)
            3'd0:    y = a + b;
            3'd1:    y = a - b;
            3'd2:    y = a & b;
            3'd3:    y = a | b;
            3'd4:    y = a ^ b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/grp_alu_regs.sv
module grp_alu_regs
    import grp_alu_pkg::*;
#(
    parameter int STK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  grp_sel_t          sel,
    input  logic [OFS_W-1:0]  ra_idx,
    input  logic [OFS_W-1:0]  rb_idx,
    input  logic [OFS_W-1:0]  rc_idx,
    input  logic              lit_mode,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b
);
    localparam int SP_W = $clog2(STK_DEPTH);

    logic [DATA_W-1:0] file_q [NUM_FILE][GRP_SIZE];
    logic [DATA_W-1:0] stk_q  [STK_DEPTH];
    logic [SP_W-1:0]   sp_q;

    logic            a_stk, b_stk, c_stk;
    logic            a_pop, b_pop, c_push;
    logic [SP_W-1:0] sp_b, sp_c, wr_slot;

    always_comb begin
        a_stk   = is_stack_slot(sel.ga, ra_idx);
        b_stk   = is_stack_slot(sel.gb, rb_idx);
        c_stk   = is_stack_slot(sel.gc, rc_idx);
        a_pop   = a_stk && (ra_idx == OFS_POP);
        b_pop   = b_stk && (rb_idx == OFS_POP);
        c_push  = c_stk && (rc_idx == OFS_PUSH);
        sp_b    = sp_q - SP_W'(a_pop);
        sp_c    = sp_b - SP_W'(b_pop);
        wr_slot = sp_c + SP_W'(c_push);
    end

    always_comb begin
        if (sel.ga == GRP_C)
            rd_a = const_entry(ra_idx);
        else if (a_stk)
            rd_a = stk_q[sp_q];
        else
            rd_a = file_q[sel.ga][ra_idx];
    end

    always_comb begin
        if (sel.gb == GRP_C)
            rd_b = lit_mode ? DATA_W'({rb_idx, 3'b000}) : const_entry(rb_idx);
        else if (b_stk)
            rd_b = stk_q[sp_b];
        else
            rd_b = file_q[sel.gb][rb_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < NUM_FILE; g++)
                for (int i = 0; i < GRP_SIZE; i++)
                    file_q[g][i] <= '0;
            for (int s = 0; s < STK_DEPTH; s++)
                stk_q[s] <= '0;
            sp_q <= '0;
        end else if (en) begin
            if (c_stk)
                stk_q[wr_slot] <= wdata;
            else
                file_q[sel.gc][rc_idx] <= wdata;
            sp_q <= wr_slot;
        end
    end

    // R10: idle cycles leave the stack pointer where it was
    assert_sp_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(sp_q));

    // R8: a lone push with no pops raises the pointer by one
    assert_push_step_R8: assert property (@(posedge clk) disable iff (rst)
        (en && c_push && !a_pop && !b_pop) |=> (sp_q == $past(sp_q) + SP_W'(1)));

endmodule

// File: rtl/grp_alu_unit.sv
module grp_alu_unit
    import grp_alu_pkg::*;
#(
    parameter int STK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [15:0]       instr,
    input  logic [2:0]        alu_op,
    input  logic              lit_mode,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic [1:0]        res_group,
    output logic [OFS_W-1:0]  res_index
);
    grp_sel_t          sel;
    logic [DATA_W-1:0] opnd_a, opnd_b, alu_y;
    logic [OFS_W-1:0]  ra, rb, rc;

    assign ra = instr[11:8];
    assign rb = instr[7:4];
    assign rc = instr[3:0];

    grp_alu_decode u_decode (
        .code (instr[15:12]),
        .sel  (sel)
    );

    grp_alu_regs #(.STK_DEPTH(STK_DEPTH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .en       (issue),
        .sel      (sel),
        .ra_idx   (ra),
        .rb_idx   (rb),
        .rc_idx   (rc),
        .lit_mode (lit_mode),
        .wdata    (alu_y),
        .rd_a     (opnd_a),
        .rd_b     (opnd_b)
    );

    grp_alu_alu u_alu (
        .op (alu_op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_group <= '0;
            res_index <= '0;
        end else begin
            res_valid <= issue;
            if (issue) begin
                res_data  <= alu_y;
                res_group <= sel.gc;
                res_index <= rc;
            end
        end
    end

    // R9: one result per accepted instruction, in the following cycle
    assert_result_follows_R9: assert property (@(posedge clk) disable iff (rst)
        issue |=> res_valid);
    assert_no_spurious_result_R10: assert property (@(posedge clk) disable iff (rst)
        !issue |=> !res_valid);

    // R3: decoded groups never target the constant bank
    assert_dest_not_const_R3: assert property (@(posedge clk) disable iff (rst)
        issue |-> (sel.gc != GRP_C));

    // R3: auxiliary slots never share an instruction with local or extra slots
    assert_aux_isolated_R3: assert property (@(posedge clk) disable iff (rst)
        (issue && (sel.ga == GRP_A || sel.gb == GRP_A || sel.gc == GRP_A)) |->
        !(sel.ga == GRP_L || sel.ga == GRP_X || sel.gb == GRP_L ||
          sel.gb == GRP_X || sel.gc == GRP_L || sel.gc == GRP_X));

    // R3: a constant second source only pairs with a constant first source
    assert_const_b_paired_R3: assert property (@(posedge clk) disable iff (rst)
        (issue && sel.gb == GRP_C) |-> (sel.ga == GRP_C));

    // R9: a reported destination is never the constant group
    assert_result_group_R9: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_group != 2'd3));

endmodule

// File: tb/grp_alu_unit_bench.sv
`timescale 1ns/1ps
module grp_alu_unit_bench;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue;
    logic [15:0] instr;
    logic [2:0]  alu_op;
    logic        lit_mode;
    logic        res_valid;
    logic [31:0] res_data;
    logic [1:0]  res_group;
    logic [3:0]  res_index;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    grp_alu_unit #(.STK_DEPTH(DEPTH)) u_grp_alu_unit (
        .clk(clk), .rst(rst), .issue(issue), .instr(instr), .alu_op(alu_op),
        .lit_mode(lit_mode), .res_valid(res_valid), .res_data(res_data),
        .res_group(res_group), .res_index(res_index)
    );

    typedef struct {
        logic [31:0] data;
        logic [1:0]  grp;
        logic [3:0]  idx;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    logic [31:0] m_file [3][16];
    logic [31:0] m_stk  [DEPTH];
    int          m_sp;

    function automatic logic [31:0] ref_const(input logic [3:0] i);
        logic [31:0] t [16] = '{32'd0, 32'd1, 32'd2, 32'd3, 32'd4, -32'sd2, -32'sd1,
            32'h8000, 32'h8000_0000, 32'd5, 32'd8, 32'd16, -32'sd4, -32'sd8,
            32'hFF, 32'hFFFF};
        return t[i];
    endfunction

    // {srcA, srcB, dest}: aux=0, local=1, extra=2, const=3
    function automatic logic [5:0] ref_groups(input logic [3:0] c);
        logic [5:0] t [16] = '{6'b00_00_00, 6'b11_00_00, 6'b01_01_01, 6'b01_10_01,
            6'b10_01_01, 6'b10_10_01, 6'b11_01_01, 6'b11_10_01, 6'b01_01_10,
            6'b01_10_10, 6'b10_01_10, 6'b10_10_10, 6'b11_01_10, 6'b11_10_10,
            6'b11_11_01, 6'b11_11_10};
        return t[c];
    endfunction

    function automatic logic [31:0] ref_alu(input logic [2:0] op, input logic [31:0] a, b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            default: return a;
        endcase
    endfunction

    function automatic bit stk_slot(input logic [1:0] g, input logic [3:0] i);
        return (g == 2'd0 || g == 2'd2) && i >= 4'd12;
    endfunction

    task automatic fail(input string req, input string what, input logic [31:0] got, exp_v);
        errors++;
        $display("FAIL %s %s: got %h expected %h", req, what, got, exp_v);
    endtask

    task automatic drive(input logic [3:0] code, ra, rb, rc, input logic [2:0] op,
                         input logic lit, input string req);
        logic [5:0]  g;
        logic [1:0]  ga, gb, gc;
        logic [31:0] va, vb, y;
        int          sp_b, sp_c, slot;
        bit          a_pop, b_pop;
        exp_t        e;
        g  = ref_groups(code);
        ga = g[5:4]; gb = g[3:2]; gc = g[1:0];
        if (ga == 2'd3)            va = ref_const(ra);
        else if (stk_slot(ga, ra)) va = m_stk[m_sp];
        else                       va = m_file[ga][ra];
        a_pop = stk_slot(ga, ra) && ra == 4'd13;
        sp_b  = (m_sp - int'(a_pop)) & (DEPTH - 1);
        if (gb == 2'd3)            vb = lit ? {25'd0, rb, 3'b000} : ref_const(rb);
        else if (stk_slot(gb, rb)) vb = m_stk[sp_b];
        else                       vb = m_file[gb][rb];
        b_pop = stk_slot(gb, rb) && rb == 4'd13;
        sp_c  = (sp_b - int'(b_pop)) & (DEPTH - 1);
        y = ref_alu(op, va, vb);
        if (stk_slot(gc, rc)) begin
            slot = (sp_c + int'(rc == 4'd14)) & (DEPTH - 1);
            m_stk[slot] = y;
            m_sp = slot;
        end else begin
            m_file[gc][rc] = y;
            m_sp = sp_c;
        end
        e.data = y; e.grp = gc; e.idx = rc; e.req = req;
        exp_q.push_back(e);
        instr = {code, ra, rb, rc}; alu_op = op; lit_mode = lit; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done && res_valid) begin
            exp_t e;
            checks++;
            if (exp_q.size() == 0) begin
                fail("R9", "unexpected result", res_data, 32'd0);
            end else begin
                e = exp_q.pop_front();
                if (res_data !== e.data)
                    fail(e.req, "data", res_data, e.data);
                else if (res_group !== e.grp)
                    fail(e.req, "group", {30'd0, res_group}, {30'd0, e.grp});
                else if (res_index !== e.idx)
                    fail(e.req, "index", {28'd0, res_index}, {28'd0, e.idx});
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int g = 0; g < 3; g++)
            for (int i = 0; i < 16; i++) m_file[g][i] = '0;
        for (int s = 0; s < DEPTH; s++) m_stk[s] = '0;
        m_sp = 0;
        rst = 1'b1; issue = 1'b0; instr = '0; alu_op = '0; lit_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (res_valid !== 1'b0) fail("R1", "res_valid", {31'd0, res_valid}, 32'd0);
        drive(4'd2, 4'd0, 4'd5, 4'd1, 3'd0, 1'b0, "R1");
        drive(4'd0, 4'd3, 4'd4, 4'd0, 3'd3, 1'b0, "R1");
        drive(4'd11, 4'd12, 4'd12, 4'd0, 3'd0, 1'b0, "R1");
        // R4: every bank entry copied into a local register
        for (int i = 0; i < 16; i++)
            drive(4'd14, 4'(i), 4'd0, 4'(i), 3'd0, 1'b0, "R4");
        // R5: literal second source, and bank second source with lit_mode low
        for (int i = 0; i < 16; i++)
            drive(4'd15, 4'd0, 4'(i), 4'(i % 12), 3'd3, 1'b1, "R5");
        drive(4'd15, 4'd1, 4'd6, 4'd0, 3'd0, 1'b0, "R5");
        drive(4'd14, 4'd4, 4'd15, 4'd2, 3'd1, 1'b1, "R5");
        // R6: every operation code on local registers
        for (int op = 0; op < 8; op++)
            drive(4'd2, 4'd7, 4'd15, 4'(op), 3'(op), 1'b0, "R6");
        // R2: every group code
        for (int c = 0; c < 16; c++)
            drive(4'(c), 4'((c * 5) % 12), 4'((c * 7) % 12), 4'((c * 3) % 12),
                  3'(c % 5), 1'(c[0]), "R2");
        // R8: pushes through the extra and auxiliary groups
        drive(4'd15, 4'd1, 4'd2, 4'd14, 3'd0, 1'b1, "R8");
        drive(4'd15, 4'd2, 4'd5, 4'd14, 3'd0, 1'b1, "R8");
        drive(4'd15, 4'd3, 4'd9, 4'd14, 3'd0, 1'b1, "R8");
        drive(4'd0, 4'd12, 4'd1, 4'd14, 3'd0, 1'b0, "R8");
        drive(4'd13, 4'd6, 4'd12, 4'd15, 3'd4, 1'b0, "R8");
        // R7: pops, double pop, pop plus push in one instruction
        drive(4'd11, 4'd13, 4'd12, 4'd3, 3'd1, 1'b0, "R7");
        drive(4'd11, 4'd13, 4'd13, 4'd14, 3'd0, 1'b0, "R7");
        drive(4'd0, 4'd13, 4'd12, 4'd15, 3'd2, 1'b0, "R7");
        drive(4'd10, 4'd3, 4'd13, 4'd12, 3'd0, 1'b0, "R7");
        for (int i = 0; i < 10; i++)
            drive(4'd11, 4'd13, 4'd13, 4'd13, 3'd0, 1'b0, "R7");
        drive(4'd9, 4'd4, 4'd14, 4'd5, 3'd0, 1'b0, "R7");
        // R2: random instructions against the model
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[15:12], r[11:8], r[7:4], r[3:0], r[18:16], r[19], "R2");
        end
        // R10: garbage with issue low
        for (int n = 0; n < 6; n++) begin
            instr = 16'(n * 16'h1357); alu_op = 3'(n); lit_mode = 1'(n);
            @(negedge clk);
            checks++;
            if (res_valid !== 1'b0) fail("R10", "res_valid", {31'd0, res_valid}, 32'd0);
        end
        for (int i = 0; i < 16; i++)
            drive(4'd2, 4'(i), 4'd0, 4'(i), 3'd5, 1'b0, "R10");
        for (int i = 0; i < 12; i++)
            drive(4'd11, 4'(i), 4'd0, 4'(i), 3'd5, 1'b0, "R10");
        for (int i = 0; i < 12; i++)
            drive(4'd0, 4'(i), 4'd0, 4'(i), 3'd5, 1'b0, "R10");
        drive(4'd11, 4'd12, 4'd0, 4'd0, 3'd5, 1'b0, "R10");
        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) fail("R9", "results missing", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule